// File: doc/BRIEF.md
# Shift and Rotate Unit

This block is the shift and rotate datapath of a small processor core. Each clock it takes a 32-bit operand from a register, the current carry flag, an operation code, a size code and a one-or-two count select. It returns the new register value and the N, Z, V and C condition flags on the following clock edge. The new value is written back into the register that supplied the operand.

Only the low byte, the low half or the whole register takes part in the operation. Bits above the selected size are carried through untouched. Eight operations are available: arithmetic, logical, plain rotate and rotate through carry, each in both directions. The distance is one or two bit positions. In a two-position move the result is the same as two single moves in a row.

Top module: `srot_unit`

## Requirements
- R1: `size_i` selects how many low bits take part: 2'b00 gives 8, 2'b01 gives 16, and 2'b10 or 2'b11 gives all 32.
- R2: `two_i` = 0 moves the selected field by one bit position and `two_i` = 1 moves it by two. A two-position move equals two single moves in a row, with the second move taking the first move's carry.
- R3: Op code 0 is an arithmetic left shift, which brings zero into bit 0. Op code 1 is an arithmetic right shift, which fills the vacated top bit of the field with a copy of the field's sign bit.
- R4: Op code 2 is a logical left shift, which brings zero into bit 0. Op code 3 is a logical right shift, which brings zero into the top bit of the field.
- R5: Op code 4 rotates the field left and op code 5 rotates it right. A bit that leaves one end of the field enters at the other end.
- R6: Op code 6 rotates left through carry and op code 7 rotates right through carry. The field and `carry_i` together form one ring of width+1 bits.
- R7: `flag_c_o` is the last bit moved out of the field.
- R8: For the 8-bit and 16-bit sizes, `result_o` bits above the field equal the operand bits in the same positions.
- R9: `flag_n_o` is the top bit of the result field. `flag_z_o` is set exactly when the result field is all zeros.
- R10: `flag_v_o` is set by an arithmetic left shift when the field's sign bit changes at any step. It is zero for every other operation.
- R11: Results and flags appear on the rising clock edge after the inputs are presented. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_i | input | 32 | Register operand |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 3 | Operation code (R3 to R6) |
| size_i | input | 2 | Operand size code (R1) |
| two_i | input | 1 | Count select: 0 for one position, 1 for two |
| result_o | output | 32 | Value written back to the register |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |

## Verification
The checker tests invariants on every cycle against the previous cycle's inputs:
- untouched upper bits for the byte and half sizes;
- V staying zero outside the arithmetic left shift;
- unchanged bit count under plain rotation;
- sign retention under the arithmetic right shift and a cleared top bit after a logical right shift;
- Z and N never both set.

The exact bit patterns cannot be expressed as such invariants. These are shown by the bench's scenarios: the carry ring of the through-carry rotates, which bit C takes, overflow on a two-step shift, the treatment of size code 3, and the reset clearing and one-edge latency.

// File: rtl/srot_pkg.sv
package srot_pkg;

    typedef enum logic [2:0] {
        OP_ASL = 3'd0,
        OP_ASR = 3'd1,
        OP_LSL = 3'd2,
        OP_LSR = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5,
        OP_RCL = 3'd6,
        OP_RCR = 3'd7
    } op_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_FULL = 2'd2,
        SZ_FULL_ALT = 2'd3
    } size_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam int NUM_LANES = 3;

endpackage

// File: rtl/srot_step.sv
module srot_step
    import srot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    input  logic         cin_i,
    input  op_t          op_i,
    output logic [W-1:0] val_o,
    output logic         cout_o,
    output logic         sgn_flip_o
);

    localparam int MSB = W - 1;

    always_comb begin
        val_o  = val_i;
        cout_o = 1'b0;
        unique case (op_i)
            OP_ASL, OP_LSL: begin
                val_o  = {val_i[MSB-1:0], 1'b0};
                cout_o = val_i[MSB];
            end
            OP_ASR: begin
                val_o  = {val_i[MSB], val_i[MSB:1]};
                cout_o = val_i[0];
            end
            OP_LSR: begin
                val_o  = {1'b0, val_i[MSB:1]};
                cout_o = val_i[0];
            end
            OP_ROL: begin
                val_o  = {val_i[MSB-1:0], val_i[MSB]};
                cout_o = val_i[MSB];
            end
            OP_ROR: begin
                val_o  = {val_i[0], val_i[MSB:1]};
                cout_o = val_i[0];
            end
            OP_RCL: begin
                val_o  = {val_i[MSB-1:0], cin_i};
                cout_o = val_i[MSB];
            end
            OP_RCR: begin
                val_o  = {cin_i, val_i[MSB:1]};
                cout_o = val_i[0];
            end
            default: begin
                val_o  = val_i;
                cout_o = cin_i;
            end
        endcase
    end

    // the sign changes on this step when the two top bits differ
    assign sgn_flip_o = (op_i == OP_ASL) && (val_i[MSB] != val_i[MSB-1]);

endmodule

// File: rtl/srot_lane.sv
module srot_lane
    import srot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    input  logic         cin_i,
    input  op_t          op_i,
    input  logic         two_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         v_o
);

    logic [W-1:0] s1_val;
    logic [W-1:0] s2_val;
    logic         s1_c;
    logic         s2_c;
    logic         s1_flip;
    logic         s2_flip;

    srot_step #(.W(W)) u_first (
        .val_i      (val_i),
        .cin_i      (cin_i),
        .op_i       (op_i),
        .val_o      (s1_val),
        .cout_o     (s1_c),
        .sgn_flip_o (s1_flip)
    );

    srot_step #(.W(W)) u_second (
        .val_i      (s1_val),
        .cin_i      (s1_c),
        .op_i       (op_i),
        .val_o      (s2_val),
        .cout_o     (s2_c),
        .sgn_flip_o (s2_flip)
    );

    always_comb begin
        if (two_i) begin
            res_o = s2_val;
            c_o   = s2_c;
            v_o   = s1_flip | s2_flip;
        end else begin
            res_o = s1_val;
            c_o   = s1_c;
            v_o   = s1_flip;
        end
    end

endmodule

// File: rtl/srot_unit.sv
module srot_unit
    import srot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              carry_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic              two_i,
    output logic [DATA_W-1:0] result_o,
    output logic              flag_c_o,
    output logic              flag_v_o,
    output logic              flag_z_o,
    output logic              flag_n_o
);

    localparam int BYTE_W = DATA_W / 4;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        flags_t            flags;
    } state_t;

    op_t               op_sel;
    logic [DATA_W-1:0] lane_res [NUM_LANES];
    logic              lane_c   [NUM_LANES];
    logic              lane_v   [NUM_LANES];
    logic [DATA_W-1:0] lane_mask[NUM_LANES];
    logic              lane_sgn [NUM_LANES];

    state_t state_d;
    state_t state_q;

    assign op_sel = op_t'(op_i);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = BYTE_W << g;
        logic [LW-1:0] res_w;

        srot_lane #(.W(LW)) u_lane (
            .val_i (opnd_i[LW-1:0]),
            .cin_i (carry_i),
            .op_i  (op_sel),
            .two_i (two_i),
            .res_o (res_w),
            .c_o   (lane_c[g]),
            .v_o   (lane_v[g])
        );

        assign lane_res[g]  = DATA_W'(res_w);
        assign lane_mask[g] = DATA_W'({LW{1'b1}});
        assign lane_sgn[g]  = res_w[LW-1];
    end

    always_comb begin
        int unsigned       idx;
        logic [DATA_W-1:0] field;

        unique case (size_t'(size_i))
            SZ_BYTE: idx = 0;
            SZ_HALF: idx = 1;
            default: idx = 2;
        endcase

        field                = lane_res[idx] & lane_mask[idx];
        state_d.result       = (opnd_i & ~lane_mask[idx]) | field;
        state_d.flags.n      = lane_sgn[idx];
        state_d.flags.z      = (field == '0);
        state_d.flags.v      = lane_v[idx];
        state_d.flags.c      = lane_c[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign flag_n_o = state_q.flags.n;
    assign flag_z_o = state_q.flags.z;
    assign flag_v_o = state_q.flags.v;
    assign flag_c_o = state_q.flags.c;

endmodule

// File: rtl/srot_unit_chk.sv
module srot_unit_chk
    import srot_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] opnd_i,
    input logic [2:0]  op_i,
    input logic [1:0]  size_i,
    input logic [31:0] result_o,
    input logic        flag_v_o,
    input logic        flag_z_o,
    input logic        flag_n_o
);

    // set from the second edge after reset release, when $past is meaningful
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    a_r8_upper_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(size_i) == SZ_BYTE) |-> result_o[31:8] == $past(opnd_i[31:8]));

    a_r8_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(size_i) == SZ_HALF) |-> result_o[31:16] == $past(opnd_i[31:16]));

    a_r10_v_only_asl: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) != OP_ASL) |-> !flag_v_o);

    a_r5_rotate_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(op_i) == OP_ROL || $past(op_i) == OP_ROR))
        |-> $countones(result_o) == $countones($past(opnd_i)));

    a_r3_asr_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_ASR && $past(size_i[1]))
        |-> result_o[31] == $past(opnd_i[31]));

    a_r4_lsr_clears_top: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_LSR && $past(size_i[1])) |-> !result_o[31]);

    a_r9_zero_not_negative: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z_o |-> !flag_n_o);

endmodule

bind srot_unit srot_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opnd_i   (opnd_i),
    .op_i     (op_i),
    .size_i   (size_i),
    .result_o (result_o),
    .flag_v_o (flag_v_o),
    .flag_z_o (flag_z_o),
    .flag_n_o (flag_n_o)
);

// File: tb/srot_unit_test.sv
`timescale 1ns/1ps
module srot_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_i = '0;
    logic        carry_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic        two_i = 1'b0;
    logic [31:0] result_o;
    logic        flag_c_o, flag_v_o, flag_z_o, flag_n_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    srot_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .opnd_i   (opnd_i),
        .carry_i  (carry_i),
        .op_i     (op_i),
        .size_i   (size_i),
        .two_i    (two_i),
        .result_o (result_o),
        .flag_c_o (flag_c_o),
        .flag_v_o (flag_v_o),
        .flag_z_o (flag_z_o),
        .flag_n_o (flag_n_o)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic        two;
        logic        cin;
        logic [31:0] a;
        logic [31:0] r;
        logic [3:0]  f;     // {n, z, v, c}
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 2'd0, 1'b0, 1'b0, 32'hAABBCC40, 32'hAABBCC80, 4'b1010, 8'd10}, // R10 R3 byte ASL sets V
        '{3'd1, 2'd1, 1'b1, 1'b0, 32'h12348003, 32'h1234E000, 4'b1001, 8'd3},  // R3 R2 half ASR x2
        '{3'd3, 2'd2, 1'b1, 1'b0, 32'h80000003, 32'h20000000, 4'b0001, 8'd4},  // R4 full LSR x2
        '{3'd2, 2'd0, 1'b1, 1'b0, 32'hFFFFFFC0, 32'hFFFFFF00, 4'b0101, 8'd8},  // R8 R9 byte LSL to zero
        '{3'd4, 2'd1, 1'b0, 1'b0, 32'h00008001, 32'h00000003, 4'b0001, 8'd5},  // R5 half ROL
        '{3'd5, 2'd0, 1'b1, 1'b0, 32'h11111101, 32'h11111140, 4'b0000, 8'd7},  // R7 R5 byte ROR x2
        '{3'd6, 2'd0, 1'b1, 1'b1, 32'h00000080, 32'h00000003, 4'b0000, 8'd6},  // R6 byte ring x2
        '{3'd7, 2'd2, 1'b0, 1'b1, 32'h00000001, 32'h80000000, 4'b1001, 8'd6},  // R6 full RCR
        '{3'd0, 2'd2, 1'b1, 1'b0, 32'h20000000, 32'h80000000, 4'b1010, 8'd10}, // R10 V on second step
        '{3'd3, 2'd3, 1'b0, 1'b0, 32'h00000100, 32'h00000080, 4'b0000, 8'd1},  // R1 size code 3 is full
        '{3'd1, 2'd0, 1'b0, 1'b0, 32'hFFFFFF7F, 32'hFFFFFF3F, 4'b0001, 8'd3}   // R3 byte ASR positive
    };

    function automatic logic [35:0] model(int op, int w, int cnt, logic cin, logic [31:0] x);
        logic [31:0] v = x;
        logic        c = cin;
        logic        vf = 1'b0;
        logic        t;
        logic [31:0] mask;
        logic [31:0] r;
        for (int k = 0; k < cnt; k++) begin
            case (op)
                0: begin if (v[w-1] != v[w-2]) vf = 1'b1; c = v[w-1]; v = v << 1; end
                1: begin c = v[0]; t = v[w-1]; v = v >> 1; v[w-1] = t; end
                2: begin c = v[w-1]; v = v << 1; end
                3: begin c = v[0]; v = v >> 1; v[w-1] = 1'b0; end
                4: begin c = v[w-1]; v = v << 1; v[0] = c; end
                5: begin c = v[0]; v = v >> 1; v[w-1] = c; end
                6: begin t = v[w-1]; v = v << 1; v[0] = c; c = t; end
                default: begin t = v[0]; v = v >> 1; v[w-1] = c; c = t; end
            endcase
        end
        mask = (w == 32) ? 32'hFFFFFFFF : ((32'd1 << w) - 32'd1);
        r = (x & ~mask) | (v & mask);
        return {r, r[w-1], (r & mask) == 32'd0, vf, c};
    endfunction

    task automatic check(string req, logic [35:0] got, logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h/%b expected %h/%b", req, got[35:4], got[3:0], exp[35:4], exp[3:0]);
        end
    endtask

    function automatic logic [35:0] outs();
        return {result_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o};
    endfunction

    task automatic drive(logic [2:0] op, logic [1:0] sz, logic two, logic cin, logic [31:0] a);
        op_i = op; size_i = sz; two_i = two; carry_i = cin; opnd_i = a;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset holds outputs at zero even with live inputs
        drive(3'd4, 2'd2, 1'b0, 1'b1, 32'hDEADBEEF);
        repeat (2) @(negedge clk);
        check("R11 reset", outs(), 36'h0);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VEC[i].op, VEC[i].sz, VEC[i].two, VEC[i].cin, VEC[i].a);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), outs(), {VEC[i].r, VEC[i].f});
        end

        // R11: output changes only at the next rising edge
        drive(3'd4, 2'd2, 1'b0, 1'b0, 32'h00000001);
        #1;
        check("R11 hold before edge", outs(), {VEC[NVEC-1].r, VEC[NVEC-1].f});
        @(negedge clk);
        check("R11 after edge", outs(), {32'h00000002, 4'b0000});

        // R2 R7 R8 R9 and all ops: sweep against the model
        for (int op = 0; op < 8; op++)
            for (int s = 0; s < 3; s++)
                for (int n = 1; n <= 2; n++)
                    for (int ci = 0; ci < 2; ci++)
                        for (int j = 0; j < 5; j++) begin
                            logic [31:0] a;
                            case (j)
                                0: a = 32'h80000001;
                                1: a = 32'h4000C081;
                                2: a = 32'hC3A55A3C;
                                3: a = 32'h00000000;
                                default: a = 32'h7FFF7F40;
                            endcase
                            drive(3'(op), 2'(s), 1'(n - 1), 1'(ci), a);
                            @(negedge clk);
                            check($sformatf("R2 sweep op%0d size%0d n%0d", op, s, n), outs(),
                                  model(op, 8 << s, n, 1'(ci), a));
                        end

        // R11: asynchronous reset mid-run clears outputs
        drive(3'd7, 2'd2, 1'b0, 1'b1, 32'h00000001);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11 async clear", outs(), 36'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule